// File: doc/BRIEF.md
# Four-Stage Pipeline Operand Forwarding Control

This block supplies the operand-select controls and forwarded operands for the combined execute/memory stage of a four-stage, in-order integer pipeline. The stages are fetch, decode with register read, a merged stage where the ALU and the data memory work side by side, and writeback. Loads and stores in this pipeline use the base register value directly as the address. A nonzero displacement therefore costs a separate add-immediate that rewrites the base register first, and that add-immediate is usually the instruction directly before the memory access.

In decode, the block compares the two source register numbers with the destination numbers of the older instructions in the merged stage and in writeback. It registers one select per operand into the merged stage, where a three-input mux picks the operand. The three inputs are the value read from the register file, the merged stage's result (ALU output or load data) captured at the end of the previous cycle, and a retired writeback result. A load result leaves the merged stage at the same time as an ALU result. A dependent instruction placed directly after a load is therefore served by forwarding, and no bubble is needed. The stall output exists so that this can be observed.

The parameter `RF_WRITE_FIRST` describes the register file. When it is 1 (the default), a write lands in the first half of a cycle and a read sees it in the second half, so a writeback-to-decode dependence is served by the register file itself. When it is 0, that dependence is forwarded from the retired result instead.

Top module: `fwd4_unit`

## Requirements
- R1: While reset is held and right after it, both selects read 00 (register file), both operands are 0 and stall is low.
- R2: Select codes are 00 = register file value, 01 = merged-stage result, 10 = retired writeback result. The decode instruction may be valid and read a register that the instruction one stage ahead (valid, writing, destination not zero) will write. In that case its select in the merged stage on the next cycle is 01, and its operand equals the result the producer presented at the merged stage one cycle earlier.
- R3: Operand A follows source 1 and operand B follows source 2. Each operand is selected on its own, so one operand can be forwarded while the other reads the register file.
- R4: Stall is never asserted, including for a load followed at once by an instruction reading the loaded register. That instruction enters the merged stage on the very next cycle and receives the load data.
- R5: A producer whose destination is register 0 is never forwarded, and the operand keeps the register file value.
- R6: A producer that does not write a register, or that is a bubble (not valid), is never forwarded.
- R7: With `RF_WRITE_FIRST`=1, a match against the instruction two stages ahead (in writeback) gives select 00, and the operand is the register file value read in decode.
- R8: If both older instructions write the register being read, the one in the merged stage wins (select 01 with the newer value).
- R9: With `RF_WRITE_FIRST`=0, a match only against the writeback instruction gives select 10, and the operand equals the result that producer presented at the merged stage two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | Decode holds a real instruction |
| idRs1 | input | REG_BITS | Source register 1 number in decode |
| idRs2 | input | REG_BITS | Source register 2 number in decode |
| idRd | input | REG_BITS | Destination register number in decode |
| idRegWrite | input | 1 | Decode instruction writes its destination |
| idRfA | input | XLEN | Register file read data for source 1 |
| idRfB | input | XLEN | Register file read data for source 2 |
| xResult | input | XLEN | Merged-stage result this cycle (ALU output or load data) |
| opA | output | XLEN | Selected operand A in the merged stage |
| opB | output | XLEN | Selected operand B in the merged stage |
| selA | output | 2 | Operand A select in the merged stage |
| selB | output | 2 | Operand B select in the merged stage |
| stall | output | 1 | Decode hold request |

## Verification
The bound checker watches every cycle to confirm that the block takes a forward whenever the producer two cycles back matches a source one cycle back. It also confirms that a forwarded operand carries exactly the merged-stage result of the right earlier cycle, that register 0 never leads to a merged-stage forward, and that no select code outside the three legal values appears. Other behaviour shows up only in the directed scenarios, because each needs a chosen sequence of instructions: priority when both older stages match, the no-bubble load-use case, the split between operands, and the contrast between the write-first register file and the variant that forwards from writeback.

// File: rtl/fwd4_pkg.sv
package fwd4_pkg;

  // Operand source codes seen on the select outputs
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_CMB = 2'b01,
    SEL_WB  = 2'b10
  } opSel_e;

  // Number of source operands per instruction
  localparam int unsigned NUM_SRC = 2;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    opSel_e [NUM_SRC-1:0] sel;
    logic                 stall;
  } fwdCtl_t;

endpackage

// File: rtl/fwd4_ctrl.sv
module fwd4_ctrl
  import fwd4_pkg::*;
#(
  parameter int unsigned REG_BITS       = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic                               idValid,
  input  logic [NUM_SRC-1:0][REG_BITS-1:0]   idRs,
  input  logic                               xValid,
  input  logic                               xWe,
  input  logic [REG_BITS-1:0]                xRd,
  input  logic                               wValid,
  input  logic                               wWe,
  input  logic [REG_BITS-1:0]                wRd,
  output fwdCtl_t                            ctl
);

  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  // Only a valid, writing producer with a real destination may forward
  logic xLive;
  logic wLive;
  assign xLive = xValid && xWe && (xRd != ZERO_REG);
  assign wLive = wValid && wWe && (wRd != ZERO_REG);

  // Code used for a writeback-distance match, chosen by register file timing
  opSel_e wbChoice;
  generate
    if (RF_WRITE_FIRST) begin : g_rfWriteFirst
      assign wbChoice = SEL_RF;
    end else begin : g_rfForwardWb
      assign wbChoice = SEL_WB;
    end
  endgenerate

  opSel_e [NUM_SRC-1:0] selNext;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_comb begin
        selNext[i] = SEL_RF;
        if (idValid) begin
          // merged stage holds the newer value, so it is tested first
          if (xLive && (idRs[i] == xRd)) begin
            selNext[i] = SEL_CMB;
          end else if (wLive && (idRs[i] == wRd)) begin
            selNext[i] = wbChoice;
          end
        end
      end
    end
  endgenerate

  // Load data is ready at the end of the merged stage like an ALU result,
  // so no dependence in this pipeline requires a bubble.
  always_comb begin
    ctl.sel   = selNext;
    ctl.stall = 1'b0;
  end

endmodule

// File: rtl/fwd4_datapath.sv
module fwd4_datapath
  import fwd4_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned REG_BITS = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             idValid,
  input  logic                             idWe,
  input  logic [REG_BITS-1:0]              idRd,
  input  logic [NUM_SRC-1:0][XLEN-1:0]     idRf,
  input  logic [XLEN-1:0]                  xResult,
  input  fwdCtl_t                          ctl,
  output logic                             xValid,
  output logic                             xWe,
  output logic [REG_BITS-1:0]              xRd,
  output logic                             wValid,
  output logic                             wWe,
  output logic [REG_BITS-1:0]              wRd,
  output logic [NUM_SRC-1:0][XLEN-1:0]     op,
  output opSel_e [NUM_SRC-1:0]             xSel
);

  logic [NUM_SRC-1:0][XLEN-1:0] xRf;      // register file values carried into merged stage
  logic [XLEN-1:0]              wResult;  // merged-stage result, one cycle old
  logic [XLEN-1:0]              rResult;  // retired result, two cycles old

  // decode -> merged stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xValid <= 1'b0;
      xWe    <= 1'b0;
      xRd    <= '0;
      xRf    <= '0;
      xSel   <= {NUM_SRC{SEL_RF}};
    end else begin
      xValid <= idValid && !ctl.stall;
      xWe    <= idWe;
      xRd    <= idRd;
      xRf    <= idRf;
      xSel   <= ctl.sel;
    end
  end

  // merged stage -> writeback -> retired
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wValid  <= 1'b0;
      wWe     <= 1'b0;
      wRd     <= '0;
      wResult <= '0;
      rResult <= '0;
    end else begin
      wValid  <= xValid;
      wWe     <= xWe;
      wRd     <= xRd;
      wResult <= xResult;
      rResult <= wResult;
    end
  end

  // three-input operand muxes of the merged stage
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opMux
      always_comb begin
        case (xSel[i])
          SEL_CMB: op[i] = wResult;
          SEL_WB:  op[i] = rResult;
          default: op[i] = xRf[i];
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/fwd4_unit.sv
module fwd4_unit
  import fwd4_pkg::*;
#(
  parameter int unsigned XLEN           = 32,
  parameter int unsigned REG_BITS       = 5,
  parameter bit          RF_WRITE_FIRST = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idValid,
  input  logic [REG_BITS-1:0] idRs1,
  input  logic [REG_BITS-1:0] idRs2,
  input  logic [REG_BITS-1:0] idRd,
  input  logic                idRegWrite,
  input  logic [XLEN-1:0]     idRfA,
  input  logic [XLEN-1:0]     idRfB,
  input  logic [XLEN-1:0]     xResult,
  output logic [XLEN-1:0]     opA,
  output logic [XLEN-1:0]     opB,
  output logic [1:0]          selA,
  output logic [1:0]          selB,
  output logic                stall
);

  fwdCtl_t                      ctl;
  logic [NUM_SRC-1:0][REG_BITS-1:0] idRs;
  logic [NUM_SRC-1:0][XLEN-1:0] idRf;
  logic [NUM_SRC-1:0][XLEN-1:0] op;
  opSel_e [NUM_SRC-1:0]         xSel;
  logic                         xValid;
  logic                         xWe;
  logic [REG_BITS-1:0]          xRd;
  logic                         wValid;
  logic                         wWe;
  logic [REG_BITS-1:0]          wRd;

  assign idRs = {idRs2, idRs1};
  assign idRf = {idRfB, idRfA};

  fwd4_ctrl #(
    .REG_BITS       (REG_BITS),
    .RF_WRITE_FIRST (RF_WRITE_FIRST)
  ) u_ctrl (
    .idValid (idValid),
    .idRs    (idRs),
    .xValid  (xValid),
    .xWe     (xWe),
    .xRd     (xRd),
    .wValid  (wValid),
    .wWe     (wWe),
    .wRd     (wRd),
    .ctl     (ctl)
  );

  fwd4_datapath #(
    .XLEN     (XLEN),
    .REG_BITS (REG_BITS)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .idValid (idValid),
    .idWe    (idRegWrite),
    .idRd    (idRd),
    .idRf    (idRf),
    .xResult (xResult),
    .ctl     (ctl),
    .xValid  (xValid),
    .xWe     (xWe),
    .xRd     (xRd),
    .wValid  (wValid),
    .wWe     (wWe),
    .wRd     (wRd),
    .op      (op),
    .xSel    (xSel)
  );

  assign opA   = op[0];
  assign opB   = op[1];
  assign selA  = xSel[0];
  assign selB  = xSel[1];
  assign stall = ctl.stall;

endmodule

// File: rtl/fwd4_unit_chk.sv
module fwd4_unit_chk #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned REG_BITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                idValid,
  input logic [REG_BITS-1:0] idRs1,
  input logic [REG_BITS-1:0] idRs2,
  input logic [REG_BITS-1:0] idRd,
  input logic                idRegWrite,
  input logic [XLEN-1:0]     xResult,
  input logic [XLEN-1:0]     opA,
  input logic [XLEN-1:0]     opB,
  input logic [1:0]          selA,
  input logic [1:0]          selB
);

  localparam logic [1:0] CODE_CMB = 2'b01;
  localparam logic [1:0] CODE_WB  = 2'b10;

  // only the three legal select codes appear
  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(selA) && $onehot0(selB));

  // producer two cycles back feeding source 1 one cycle back must be forwarded
  assert_fwd_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idValid, 2) && $past(idRegWrite, 2) && ($past(idRd, 2) != '0) &&
     $past(idValid) && ($past(idRs1) == $past(idRd, 2)))
    |-> (selA == CODE_CMB));

  // same for source 2 on its own operand
  assert_fwd_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idValid, 2) && $past(idRegWrite, 2) && ($past(idRd, 2) != '0) &&
     $past(idValid) && ($past(idRs2) == $past(idRd, 2)))
    |-> (selB == CODE_CMB));

  // forwarded operands carry the merged-stage result of the previous cycle
  assert_fwd_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (selA == CODE_CMB) |-> (opA == $past(xResult)));

  assert_fwd_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (selB == CODE_CMB) |-> (opB == $past(xResult)));

  // register 0 never produces a merged-stage forward
  assert_no_zero_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idRd, 2) == '0) |-> ((selA != CODE_CMB) && (selB != CODE_CMB)));

  // writeback forwarding delivers the result from two cycles back
  assert_wb_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (selA == CODE_WB) |-> (opA == $past(xResult, 2)));

endmodule

bind fwd4_unit fwd4_unit_chk #(
  .XLEN     (XLEN),
  .REG_BITS (REG_BITS)
) u_chk (.*);

// File: tb/fwd4_unit_tb.sv
module fwd4_unit_tb;

  localparam int XLEN = 32;
  localparam int RB   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          idValid = 1'b0;
  logic [RB-1:0] idRs1 = '0;
  logic [RB-1:0] idRs2 = '0;
  logic [RB-1:0] idRd = '0;
  logic          idRegWrite = 1'b0;
  logic [XLEN-1:0] idRfA = '0;
  logic [XLEN-1:0] idRfB = '0;
  logic [XLEN-1:0] xResult = '0;

  logic [XLEN-1:0] opA, opB, altOpA, altOpB;
  logic [1:0]      selA, selB, altSelA, altSelB;
  logic            stall, altStall;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  fwd4_unit #(.XLEN(XLEN), .REG_BITS(RB), .RF_WRITE_FIRST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .idValid(idValid), .idRs1(idRs1), .idRs2(idRs2),
    .idRd(idRd), .idRegWrite(idRegWrite), .idRfA(idRfA), .idRfB(idRfB),
    .xResult(xResult), .opA(opA), .opB(opB), .selA(selA), .selB(selB), .stall(stall));

  fwd4_unit #(.XLEN(XLEN), .REG_BITS(RB), .RF_WRITE_FIRST(1'b0)) u_alt (
    .clk(clk), .rst_n(rst_n), .idValid(idValid), .idRs1(idRs1), .idRs2(idRs2),
    .idRd(idRd), .idRegWrite(idRegWrite), .idRfA(idRfA), .idRfB(idRfB),
    .xResult(xResult), .opA(altOpA), .opB(altOpB), .selA(altSelA), .selB(altSelB),
    .stall(altStall));

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Put one instruction in decode and the merged-stage result on xResult,
  // then advance one edge and settle; R4: stall checked on every step.
  task automatic issue(input logic v, input logic [RB-1:0] rs1, input logic [RB-1:0] rs2,
                       input logic [RB-1:0] rd, input logic we,
                       input logic [XLEN-1:0] rfA, input logic [XLEN-1:0] rfB,
                       input logic [XLEN-1:0] xres);
    @(negedge clk);
    idValid = v; idRs1 = rs1; idRs2 = rs2; idRd = rd; idRegWrite = we;
    idRfA = rfA; idRfB = rfB; xResult = xres;
    @(posedge clk); #2;
    chk("R4 stall low", {31'b0, stall}, 32'd0);
  endtask

  task automatic flush();
    issue(1'b0, 0, 0, 0, 1'b0, 0, 0, 0);
    issue(1'b0, 0, 0, 0, 1'b0, 0, 0, 0);
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk("R1 selA", {30'b0, selA}, 0);
    chk("R1 selB", {30'b0, selB}, 0);
    chk("R1 opA", opA, 0);
    chk("R1 opB", opB, 0);
    chk("R1 stall", {31'b0, stall}, 0);
  endtask

  task automatic t_adjacent();
    issue(1'b1, 1, 1, 3, 1'b1, 0, 0, 0);
    issue(1'b1, 3, 3, 11, 1'b1, 32'h1111, 32'h2222, 32'hAAAA_0003);
    chk("R2 selA", {30'b0, selA}, 1);
    chk("R2 opA", opA, 32'hAAAA_0003);
    chk("R3 selB", {30'b0, selB}, 1);
    chk("R3 opB", opB, 32'hAAAA_0003);
    flush();
  endtask

  task automatic t_split();
    issue(1'b1, 1, 1, 4, 1'b1, 0, 0, 0);
    issue(1'b1, 7, 4, 12, 1'b1, 32'h7777, 32'h4444, 32'hBEEF_0004);
    chk("R3 split selA", {30'b0, selA}, 0);
    chk("R3 split opA", opA, 32'h7777);
    chk("R3 split selB", {30'b0, selB}, 1);
    chk("R3 split opB", opB, 32'hBEEF_0004);
    flush();
  endtask

  // add-immediate updates base, load uses it unmodified, then ALU op uses load data
  task automatic t_loaduse();
    issue(1'b1, 2, 0, 2, 1'b1, 0, 0, 0);                      // add-immediate to r2
    issue(1'b1, 2, 0, 8, 1'b1, 32'h0, 0, 32'h0000_1000);      // load r8 from (r2)
    chk("R2 base fwd", opA, 32'h0000_1000);
    issue(1'b1, 8, 8, 9, 1'b1, 0, 0, 32'hCAFE_0008);          // add r9 = r8 + r8
    chk("R4 loaduse selA", {30'b0, selA}, 1);
    chk("R4 loaduse opA", opA, 32'hCAFE_0008);
    chk("R4 loaduse opB", opB, 32'hCAFE_0008);
    flush();
  endtask

  task automatic t_zero();
    issue(1'b1, 1, 1, 0, 1'b1, 0, 0, 0);
    issue(1'b1, 0, 0, 13, 1'b1, 32'h55, 32'h66, 32'hDEAD_0000);
    chk("R5 selA", {30'b0, selA}, 0);
    chk("R5 opA", opA, 32'h55);
    chk("R5 opB", opB, 32'h66);
    flush();
  endtask

  task automatic t_noWrite();
    issue(1'b1, 1, 1, 6, 1'b0, 0, 0, 0);
    issue(1'b1, 6, 0, 14, 1'b1, 32'h0606, 0, 32'h9999);
    chk("R6 nowrite selA", {30'b0, selA}, 0);
    chk("R6 nowrite opA", opA, 32'h0606);
    flush();
    issue(1'b0, 1, 1, 6, 1'b1, 0, 0, 0);
    issue(1'b1, 0, 6, 14, 1'b1, 0, 32'h0607, 32'h8888);
    chk("R6 bubble selB", {30'b0, selB}, 0);
    chk("R6 bubble opB", opB, 32'h0607);
    flush();
  endtask

  task automatic t_distTwo();
    issue(1'b1, 1, 1, 9, 1'b1, 0, 0, 0);
    issue(1'b1, 1, 1, 10, 1'b1, 0, 0, 32'h0009_0009);
    issue(1'b1, 9, 0, 15, 1'b1, 32'h0009_0009, 0, 32'h0010_0010);
    chk("R7 selA", {30'b0, selA}, 0);
    chk("R7 opA", opA, 32'h0009_0009);
    chk("R9 alt selA", {30'b0, altSelA}, 2);
    chk("R9 alt opA", altOpA, 32'h0009_0009);
    flush();
    // register file value differs from forwarded value to expose the source
    issue(1'b1, 1, 1, 9, 1'b1, 0, 0, 0);
    issue(1'b1, 1, 1, 10, 1'b1, 0, 0, 32'h1234_5678);
    issue(1'b1, 9, 0, 15, 1'b1, 32'h0BAD_0BAD, 0, 32'h0);
    chk("R7 rf source", opA, 32'h0BAD_0BAD);
    chk("R9 wb source", altOpA, 32'h1234_5678);
    flush();
  endtask

  task automatic t_priority();
    issue(1'b1, 1, 1, 5, 1'b1, 0, 0, 0);
    issue(1'b1, 1, 1, 5, 1'b1, 0, 0, 32'h0000_0111);
    issue(1'b1, 5, 5, 16, 1'b1, 32'h3, 32'h3, 32'h0000_0222);
    chk("R8 selA", {30'b0, selA}, 1);
    chk("R8 opA", opA, 32'h0000_0222);
    chk("R8 alt selB", {30'b0, altSelB}, 1);
    chk("R8 alt opB", altOpB, 32'h0000_0222);
    flush();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release selA", {30'b0, selA}, 0);
    chk("R1 after release opA", opA, 0);
    t_adjacent();
    t_split();
    t_loaduse();
    t_zero();
    t_noWrite();
    t_distTwo();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule